// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a general register file for a processor that passes procedure arguments in registers. Software addresses it with 5-bit logical register numbers. Logical registers 0 to 7 are global: they map to the same storage in every context. The other 24 names are translated through a current window pointer into a circular pool of 16 physical registers per window. Because a window's out registers are the in registers of the next window, a caller can place arguments in its outs, advance the window with a call strobe, and the callee sees those arguments as its ins. No data is copied.

A mask marks windows whose contents are not resident. A call into a marked window raises an overflow trap, and a return into one raises an underflow trap. In both cases the pointer stays where it is. A handler outside the block then moves one register per cycle through a save/restore port that addresses the pool by window and index. After that it updates the mask through mark commands.

Top module: `rwin_file`

## Requirements
- R1: Logical register 0 always reads as zero, and a write to it changes no state.
- R2: Logical registers 1 to 7 select one shared set of globals. A value written in one window reads back unchanged in any other window.
- R3: With N windows, a call (call_i high, ret_i low) into a valid next window moves cwp_o to (cwp+1) mod N at the next edge, and a return moves it to (cwp-1) mod N. In window w, logical 24 to 31 (ins) are pool entries 16w+0..7, logical 16 to 23 (locals) are entries 16w+8..15, and logical 8 to 15 (outs) are entries 16((w+1) mod N)+0..7. So a caller's r8+k is its callee's r24+k.
- R4: A window's locals are private. Writes made in another window leave them unchanged.
- R5: A call whose next window has its mask bit set drives ovf_o high in that same cycle and leaves cwp_o unchanged.
- R6: A return whose previous window has its mask bit set drives unf_o high in that same cycle and leaves cwp_o unchanged.
- R7: call_i and ret_i high together leave cwp_o unchanged and raise no trap.
- R8: A read of the logical register being written in the same cycle returns the new write data.
- R9: The save port reads pool entry 16*sv_win_i+sv_idx_i combinationally, with no bypass. When sv_we_i is high it writes sv_wdata_i there at the edge. If a logical write hits the same entry in the same cycle, the logical write wins.
- R10: After reset, cwp_o is 0, only mask bit N-1 is set, and both traps are low.
- R11: mark_inv_i sets and mark_val_i clears mask bit sv_win_i at the next edge. If both are high, the set wins. A trap decision uses the mask value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs1_i | input | 5 | Logical read address, port 1 |
| rs2_i | input | 5 | Logical read address, port 2 |
| rd1_o | output | DW | Read data, port 1 |
| rd2_o | output | DW | Read data, port 2 |
| we_i | input | 1 | Logical write enable |
| wa_i | input | 5 | Logical write address |
| wd_i | input | DW | Logical write data |
| call_i | input | 1 | Call strobe, advances the window |
| ret_i | input | 1 | Return strobe, retreats the window |
| ovf_o | output | 1 | Overflow trap, call blocked |
| unf_o | output | 1 | Underflow trap, return blocked |
| cwp_o | output | CW | Current window pointer |
| wim_o | output | NWIN | Invalid-window mask |
| sv_we_i | input | 1 | Save-port write enable |
| sv_win_i | input | CW | Save-port window, also the mark target |
| sv_idx_i | input | 4 | Register index within the window block |
| sv_wdata_i | input | DW | Save-port write data |
| sv_rdata_o | output | DW | Save-port read data |
| mark_inv_i | input | 1 | Set the mask bit of sv_win_i |
| mark_val_i | input | 1 | Clear the mask bit of sv_win_i |

## Verification
The assertions assume that sv_win_i names an existing window whenever a mark command is given. They also assume that reset is applied before the first strobe, so that $past of the pointer has a defined value. The stimulus always draws window numbers modulo the window count. It issues calls, returns and both together at random against a mask that the random mark commands keep changing. This drives the trap paths, the wrap from the last window to window 0 and the simultaneous-strobe case without leaving those assumptions.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int NGLOB = 8;
  localparam int WREGS = 16;
  localparam int LW    = 5;
  // decode of lreg[4:3]; order is fixed by the logical numbering
  typedef enum logic [1:0] {GRP_GLOB, GRP_OUT, GRP_LOC, GRP_IN} grp_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map import rwin_pkg::*; #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int PW = CW + 4
) (
  input  logic [CW-1:0] cwp_i,
  input  logic [LW-1:0] lreg_i,
  output logic          glob_o,
  output logic [PW-1:0] pidx_o
);
  logic [CW-1:0] nxt;
  logic [CW-1:0] blk;
  logic [3:0]    off;
  grp_e          grp;

  assign nxt = (cwp_i == CW'(NWIN-1)) ? '0 : cwp_i + CW'(1);
  assign grp = grp_e'(lreg_i[4:3]);

  always_comb begin
    glob_o = 1'b0;
    blk    = cwp_i;
    off    = {1'b0, lreg_i[2:0]};
    unique case (grp)
      GRP_GLOB: begin glob_o = 1'b1; blk = '0; end
      GRP_OUT:  blk = nxt;
      GRP_LOC:  off = {1'b1, lreg_i[2:0]};
      GRP_IN:   blk = cwp_i;
      default:  blk = cwp_i;
    endcase
  end

  assign pidx_o = {blk, off};
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            set_inv_i,
  input  logic            clr_inv_i,
  input  logic [CW-1:0]   mwin_i,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CW-1:0]   cwp_q, nxt, prv;
  logic [NWIN-1:0] wim_q;
  logic            call_go, ret_go, mwin_ok;

  assign nxt     = (cwp_q == CW'(NWIN-1)) ? '0 : cwp_q + CW'(1);
  assign prv     = (cwp_q == '0) ? CW'(NWIN-1) : cwp_q - CW'(1);
  assign call_go = call_i & ~ret_i;
  assign ret_go  = ret_i & ~call_i;
  assign ovf_o   = call_go & wim_q[nxt];
  assign unf_o   = ret_go & wim_q[prv];
  assign mwin_ok = (32'(mwin_i) < NWIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      wim_q <= NWIN'(1) << (NWIN-1);
    end else begin
      if (call_go && !ovf_o)     cwp_q <= nxt;
      else if (ret_go && !unf_o) cwp_q <= prv;
      if (mwin_ok) begin
        if (set_inv_i)      wim_q[mwin_i] <= 1'b1;
        else if (clr_inv_i) wim_q[mwin_i] <= 1'b0;
      end
    end
  end

  assign cwp_o = cwp_q;
  assign wim_o = wim_q;

  p_ovf_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> $stable(cwp_q));
  p_unf_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> $stable(cwp_q));
  p_call_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !ovf_o) |=>
      (cwp_q == (($past(cwp_q) == CW'(NWIN-1)) ? '0 : $past(cwp_q) + CW'(1))));
  p_both_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i) |=> $stable(cwp_q));
  p_mark_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_inv_i && mwin_ok) |=> wim_q[$past(mwin_i)]);
  p_one_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}));
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int PW = CW + 4,
  localparam int NPHYS = 16 * NWIN
) (
  input  logic          clk_i,
  input  logic          r1_glob_i,
  input  logic [PW-1:0] r1_idx_i,
  input  logic          r2_glob_i,
  input  logic [PW-1:0] r2_idx_i,
  input  logic          w_en_i,
  input  logic          w_glob_i,
  input  logic [PW-1:0] w_idx_i,
  input  logic [DW-1:0] w_data_i,
  input  logic          s_we_i,
  input  logic [PW-1:0] s_idx_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] s_rdata_o,
  output logic [DW-1:0] rd1_o,
  output logic [DW-1:0] rd2_o
);
  logic [DW-1:0] glob_q [8];
  logic [DW-1:0] pool_q [NPHYS];

  always_ff @(posedge clk_i) begin
    if (s_we_i) pool_q[s_idx_i] <= s_wdata_i;
    if (w_en_i) begin   // after the save write: logical write wins
      if (w_glob_i) glob_q[w_idx_i[2:0]] <= w_data_i;
      else          pool_q[w_idx_i]      <= w_data_i;
    end
  end

  assign rd1_o     = r1_glob_i ? glob_q[r1_idx_i[2:0]] : pool_q[r1_idx_i];
  assign rd2_o     = r2_glob_i ? glob_q[r2_idx_i[2:0]] : pool_q[r2_idx_i];
  assign s_rdata_o = pool_q[s_idx_i];
endmodule

// File: rtl/rwin_file.sv
module rwin_file import rwin_pkg::*; #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int PW = CW + 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LW-1:0]   rs1_i,
  input  logic [LW-1:0]   rs2_i,
  output logic [DW-1:0]   rd1_o,
  output logic [DW-1:0]   rd2_o,
  input  logic            we_i,
  input  logic [LW-1:0]   wa_i,
  input  logic [DW-1:0]   wd_i,
  input  logic            call_i,
  input  logic            ret_i,
  output logic            ovf_o,
  output logic            unf_o,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  input  logic            sv_we_i,
  input  logic [CW-1:0]   sv_win_i,
  input  logic [3:0]      sv_idx_i,
  input  logic [DW-1:0]   sv_wdata_i,
  output logic [DW-1:0]   sv_rdata_o,
  input  logic            mark_inv_i,
  input  logic            mark_val_i
);
  logic [CW-1:0] cwp;
  logic [LW-1:0] lreg [3];
  logic          glob [3];
  logic [PW-1:0] pidx [3];
  logic [DW-1:0] raw1, raw2;
  logic          wr_en;

  assign lreg[0] = rs1_i;
  assign lreg[1] = rs2_i;
  assign lreg[2] = wa_i;
  assign wr_en   = we_i && (wa_i != '0);

  for (genvar i = 0; i < 3; i++) begin : g_map
    rwin_map #(.NWIN(NWIN)) u_map (
      .cwp_i (cwp),
      .lreg_i(lreg[i]),
      .glob_o(glob[i]),
      .pidx_o(pidx[i])
    );
  end

  rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .set_inv_i(mark_inv_i),
    .clr_inv_i(mark_val_i),
    .mwin_i   (sv_win_i),
    .cwp_o    (cwp),
    .wim_o    (wim_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  rwin_store #(.NWIN(NWIN), .DW(DW)) u_store (
    .clk_i    (clk_i),
    .r1_glob_i(glob[0]),
    .r1_idx_i (pidx[0]),
    .r2_glob_i(glob[1]),
    .r2_idx_i (pidx[1]),
    .w_en_i   (wr_en),
    .w_glob_i (glob[2]),
    .w_idx_i  (pidx[2]),
    .w_data_i (wd_i),
    .s_we_i   (sv_we_i),
    .s_idx_i  ({sv_win_i, sv_idx_i}),
    .s_wdata_i(sv_wdata_i),
    .s_rdata_o(sv_rdata_o),
    .rd1_o    (raw1),
    .rd2_o    (raw2)
  );

  // r0 is hardwired zero; same-cycle write is forwarded
  assign rd1_o = (rs1_i == '0) ? '0 : (wr_en && wa_i == rs1_i) ? wd_i : raw1;
  assign rd2_o = (rs2_i == '0) ? '0 : (wr_en && wa_i == rs2_i) ? wd_i : raw2;
  assign cwp_o = cwp;

  p_glob_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_i != '0 && rs1_i < LW'(NGLOB)) |-> glob[0]);
endmodule

// File: tb/tb_rwin_file.sv
module tb_rwin_file;
  localparam int NWIN = 8;
  localparam int DW   = 32;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] rs1, rs2, wa;
  logic [DW-1:0] rd1, rd2, wd, sv_wdata, sv_rdata;
  logic we, call, ret, ovf, unf, sv_we, mark_inv, mark_val;
  logic [CW-1:0] cwp, sv_win;
  logic [NWIN-1:0] wim;
  logic [3:0] sv_idx;

  rwin_file #(.NWIN(NWIN), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rs1_i(rs1), .rs2_i(rs2), .rd1_o(rd1), .rd2_o(rd2),
    .we_i(we), .wa_i(wa), .wd_i(wd), .call_i(call), .ret_i(ret), .ovf_o(ovf), .unf_o(unf),
    .cwp_o(cwp), .wim_o(wim), .sv_we_i(sv_we), .sv_win_i(sv_win), .sv_idx_i(sv_idx),
    .sv_wdata_i(sv_wdata), .sv_rdata_o(sv_rdata), .mark_inv_i(mark_inv), .mark_val_i(mark_val)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_pool [16*NWIN];
  int m_cwp;
  logic [NWIN-1:0] m_wim;

  function automatic int nxt(int c); return (c + 1) % NWIN; endfunction
  function automatic int prv(int c); return (c + NWIN - 1) % NWIN; endfunction
  function automatic int phys(logic [4:0] r, int c);
    int k = int'(r[2:0]);
    case (r[4:3])
      2'd1:    return nxt(c) * 16 + k;
      2'd2:    return c * 16 + 8 + k;
      default: return c * 16 + k;
    endcase
  endfunction
  function automatic logic [DW-1:0] mread(logic [4:0] r);
    if (r == 0) return '0;
    if (r < 8)  return m_glob[r[2:0]];
    return m_pool[phys(r, m_cwp)];
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rs1 = 0; rs2 = 0; wa = 0; wd = 0; we = 0; call = 0; ret = 0;
    sv_we = 0; sv_win = 0; sv_idx = 0; sv_wdata = 0; mark_inv = 0; mark_val = 0;
  endtask

  task automatic cycle(string tag);
    logic [DW-1:0] e1, e2;
    logic eo, eu;
    @(negedge clk);
    e1 = (we && wa != 0 && wa == rs1) ? wd : mread(rs1);
    e2 = (we && wa != 0 && wa == rs2) ? wd : mread(rs2);
    eo = call && !ret && m_wim[nxt(m_cwp)];
    eu = ret && !call && m_wim[prv(m_cwp)];
    chk(tag, "rd1", rd1, e1);
    chk(tag, "rd2", rd2, e2);
    chk(tag, "ovf", DW'(ovf), DW'(eo));
    chk(tag, "unf", DW'(unf), DW'(eu));
    chk(tag, "cwp", DW'(cwp), DW'(m_cwp));
    chk(tag, "wim", DW'(wim), DW'(m_wim));
    chk(tag, "sv_rdata", sv_rdata, m_pool[int'(sv_win) * 16 + int'(sv_idx)]);
    @(posedge clk);
    if (sv_we) m_pool[int'(sv_win) * 16 + int'(sv_idx)] = sv_wdata;
    if (we && wa != 0) begin
      if (wa < 8) m_glob[wa[2:0]] = wd;
      else        m_pool[phys(wa, m_cwp)] = wd;
    end
    if (call && !ret && !eo)      m_cwp = nxt(m_cwp);
    else if (ret && !call && !eu) m_cwp = prv(m_cwp);
    if (mark_inv)      m_wim[sv_win] = 1'b1;
    else if (mark_val) m_wim[sv_win] = 1'b0;
    #1;
    idle();
  endtask

  task automatic wr(logic [4:0] a, logic [DW-1:0] d, string tag);
    we = 1; wa = a; wd = d; cycle(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    m_cwp = 0;
    m_wim = NWIN'(1) << (NWIN - 1);
    m_glob[0] = '0;
    #25;
    // R10: reset state while held
    chk("R10", "cwp", DW'(cwp), 0);
    chk("R10", "wim", DW'(wim), DW'(m_wim));
    chk("R10", "traps", DW'({ovf, unf}), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // fill the pool through the save port and the globals logically
    for (int i = 0; i < 16 * NWIN; i++) begin
      sv_we = 1; sv_win = CW'(i / 16); sv_idx = 4'(i % 16); sv_wdata = $urandom;
      cycle("R9");
    end
    for (int g = 1; g < 8; g++) wr(5'(g), $urandom, "R2");

    // R1: r0 write ignored, reads zero
    rs1 = 0; wr(5'd0, 32'hDEAD_BEEF, "R1");
    rs1 = 0; rs2 = 0; cycle("R1");
    // R8: bypass
    rs1 = 5'd9; rs2 = 5'd3; wr(5'd9, 32'h1234_5678, "R8");
    rs2 = 5'd3; wr(5'd3, 32'hCAFE_0003, "R8");
    // R3: outs become ins
    wr(5'd8, 32'hA0A0_0008, "R3");
    wr(5'd16, 32'h1111_0016, "R4");
    call = 1; cycle("R3");
    rs1 = 5'd24; rs2 = 5'd16; cycle("R3");
    // R4: callee local write does not reach caller local
    wr(5'd16, 32'h2222_0016, "R4");
    // R2: global written in window 1
    wr(5'd5, 32'h6060_0005, "R2");
    ret = 1; cycle("R3");
    rs1 = 5'd16; rs2 = 5'd5; cycle("R4");
    // R9: save port sees window 1 ins = window 0 outs
    sv_win = 1; sv_idx = 0; rs1 = 5'd8; cycle("R9");
    // R9: logical write beats save write on same entry
    sv_we = 1; sv_win = 1; sv_idx = 1; sv_wdata = 32'h5555_5555;
    wr(5'd9, 32'h9999_9999, "R9");
    sv_win = 1; sv_idx = 1; cycle("R9");
    // R6: return from window 0 into invalid window
    ret = 1; cycle("R6");
    cycle("R6");
    // R7: both strobes
    call = 1; ret = 1; cycle("R7");
    cycle("R7");
    // R5: calls until blocked by window NWIN-1
    for (int i = 0; i < NWIN - 1; i++) begin call = 1; cycle("R5"); end
    cycle("R5");
    for (int i = 0; i < NWIN - 2; i++) begin ret = 1; cycle("R3"); end
    // R11: mark window 1 invalid, call blocked; set wins over clear
    mark_inv = 1; mark_val = 1; sv_win = 1; cycle("R11");
    call = 1; cycle("R11");
    mark_val = 1; sv_win = 1; call = 1; cycle("R11");
    call = 1; cycle("R11");
    ret = 1; cycle("R11");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 16;
      rs1 = 5'($urandom); rs2 = 5'($urandom);
      we = ($urandom % 2) == 0; wa = 5'($urandom); wd = $urandom;
      call = (r < 4) || (r == 8); ret = (r >= 4 && r < 8) || (r == 8);
      sv_win = CW'($urandom % NWIN); sv_idx = 4'($urandom);
      sv_we = ($urandom % 8) == 0; sv_wdata = $urandom;
      mark_inv = ($urandom % 32) == 0; mark_val = ($urandom % 24) == 0;
      cycle("R3/R8 random");
    end
    finish_run();
  end
endmodule